// File: doc/BRIEF.md
# Rotating end-around-carry checksum engine

This block computes a 16-bit checksum over a run of words held in memory. A start pulse loads a 32-bit word address, a word count and an initial checksum. The engine then reads memory one aligned quadword (four words) at a time and folds the words in one after another. Each word is added to the running sum with one's-complement addition, where the carry out of the top bit is fed back into bit 0. The result of that add is then rotated left by one bit.

The first quadword may be entered partway through: the low two address bits select the first word used. After the last word of each quadword, if more words remain, the engine samples an interrupt-pending input. When that input is set, the engine stops and exposes its updated address, remaining count and raw partial checksum. A later start with those three values picks the job up where it left off. When the count runs out, the final checksum is reported, with an all-ones value replaced by zero.

Top module: `csum_engine`

## Requirements
- R1: For each word w, the sum s becomes rotl1(e), where e = s + w with the carry out of bit 15 added back into bit 0, and rotl1 rotates left by one bit.
- R2: On the done pulse, `result` is 0x0000 when the final sum is 0xFFFF; otherwise `result` is the final sum.
- R3: A start with a count of zero gives a done pulse in the cycle after the start is sampled. `result` is then the initial sum, with the R2 rule applied.
- R4: `rd_addr` always has bits [1:0] equal to 0. The words of `rd_data` are ordered so that word i sits at bits [16*i+15:16*i]. Processing begins with word start_addr[1:0] of the first quadword.
- R5: The word address is a 32-bit value that increases by one per word, so a carry out of bits [15:0] increments bits [31:16].
- R6: After the last word of a quadword, if the count is not zero and `irq_pend` is 1, the engine pulses `suspended`. At that point `cur_addr` is the next word address (bits [1:0] = 0), `cur_count` is the number of words left and `result` is the raw partial sum. A restart with those values gives the same final result as an uninterrupted run.
- R7: The count drops by one per word. The engine finishes as soon as the count reaches zero, even in the middle of a quadword, and `cur_count` is then 0.
- R8: `done` and `suspended` are each one-cycle pulses and are never high in the same cycle.
- R9: A start while `busy` is 1 is ignored and does not change the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; sampled only while idle |
| start_addr | input | 32 | First word address |
| start_count | input | 16 | Number of words to fold |
| start_sum | input | 16 | Initial checksum |
| rd_req | output | 1 | Quadword read request, held until `rd_valid` |
| rd_addr | output | 32 | Quadword-aligned word address of the read |
| rd_valid | input | 1 | Read data valid this cycle |
| rd_data | input | 64 | Quadword read data; word i sits at bits [16*i+15:16*i] |
| irq_pend | input | 1 | Interrupt pending; sampled at quadword boundaries |
| busy | output | 1 | A job is in progress |
| result | output | 16 | Checksum; valid on a `done` or `suspended` pulse |
| done | output | 1 | One-cycle pulse: the job finished |
| suspended | output | 1 | One-cycle pulse: the job stopped at a boundary |
| cur_addr | output | 32 | Current word address (resume value) |
| cur_count | output | 16 | Words remaining (resume value) |

## Verification
A wrong lane select or address step shows up at `result` on the very next `done`, because each word passes through a rotate. Any misplaced or repeated word therefore changes the checksum, unlike a plain sum that ignores word order. A wrong count decrement or boundary test shows up at that same pulse as a wrong `cur_count` or `cur_addr`, or as a `suspended` pulse in mid-quadword. A lost carry at the 64K crossing is exposed within the first word fetched past it. A bad partial-sum hand-off only appears after the resumed job's `done`, when its result is compared against an uninterrupted run.

// File: rtl/csum_engine.sv
module csum_engine #(
  parameter int W     = 16,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [AW-1:0]      start_addr,
  input  logic [CW-1:0]      start_count,
  input  logic [W-1:0]       start_sum,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr,
  input  logic               rd_valid,
  input  logic [LANES*W-1:0] rd_data,
  input  logic               irq_pend,
  output logic               busy,
  output logic [W-1:0]       result,
  output logic               done,
  output logic               suspended,
  output logic [AW-1:0]      cur_addr,
  output logic [CW-1:0]      cur_count
);
  localparam int LB = $clog2(LANES);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_FOLD} state_t;

  state_t             state;
  logic [AW-1:0]      addr_q;
  logic [CW-1:0]      cnt_q;
  logic [W-1:0]       sum_q;
  logic [LANES*W-1:0] qbuf;
  logic               done_q, susp_q;

  logic [W-1:0]  word;
  logic [W:0]    raw_add;
  logic [W-1:0]  eac;
  logic [W-1:0]  next_sum;
  logic [AW-1:0] next_addr;
  logic [CW-1:0] next_cnt;
  logic          take;

  assign word      = qbuf[addr_q[LB-1:0]*W +: W];
  assign raw_add   = {1'b0, sum_q} + {1'b0, word};
  assign eac       = raw_add[W-1:0] + {{(W-1){1'b0}}, raw_add[W]};
  assign next_sum  = {eac[W-2:0], eac[W-1]};
  assign next_addr = addr_q + 1'b1;
  assign next_cnt  = cnt_q - 1'b1;
  assign take      = start && state == S_IDLE;

  assign busy      = state != S_IDLE;
  assign rd_req    = state == S_FETCH;
  assign rd_addr   = {addr_q[AW-1:LB], {LB{1'b0}}};
  assign cur_addr  = addr_q;
  assign cur_count = cnt_q;
  assign done      = done_q;
  assign suspended = susp_q;
  assign result    = (done_q && sum_q == ONES) ? '0 : sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
      qbuf   <= '0;
      done_q <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      susp_q <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          addr_q <= start_addr;
          cnt_q  <= start_count;
          sum_q  <= start_sum;
          if (start_count == '0) done_q <= 1'b1;
          else state <= S_FETCH;
        end
        S_FETCH: if (rd_valid) begin
          qbuf  <= rd_data;
          state <= S_FOLD;
        end
        S_FOLD: begin
          sum_q  <= next_sum;
          addr_q <= next_addr;
          cnt_q  <= next_cnt;
          if (next_cnt == '0) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else if (next_addr[LB-1:0] == '0) begin
            if (irq_pend) begin
              state  <= S_IDLE;
              susp_q <= 1'b1;
            end else begin
              state <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && suspended));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_count == '0) |=> done);
  // R2
  no_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result != ONES);
  // R7
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cur_count == '0);
  // R6
  susp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (cur_addr[LB-1:0] == '0 && cur_count != '0));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done && !suspended) |=> $stable(cur_count) || !rd_req);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: tb/sim_csum_engine.sv
module sim_csum_engine;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic        start = 0;
  logic [31:0] start_addr = 0;
  logic [15:0] start_count = 0, start_sum = 0;
  logic        rd_req, rd_valid = 0;
  logic [31:0] rd_addr;
  logic [63:0] rd_data = 0;
  logic        irq_pend = 0;
  logic        busy, done, suspended;
  logic [15:0] result, cur_count;
  logic [31:0] cur_addr;

  int checks = 0, fails = 0, cyc = 0;

  csum_engine u0 (.clk, .rst_n, .start, .start_addr, .start_count, .start_sum,
    .rd_req, .rd_addr, .rd_valid, .rd_data, .irq_pend, .busy, .result,
    .done, .suspended, .cur_addr, .cur_count);

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [15:0] mw(input logic [31:0] a);
    return (a[15:0] ^ 16'h00C3) * 16'h9E37 + a[31:16];
  endfunction

  always @(posedge clk) begin
    rd_valid <= rd_req && !rd_valid;
    rd_data  <= {mw(rd_addr+3), mw(rd_addr+2), mw(rd_addr+1), mw(rd_addr)};
  end

  function automatic logic [15:0] fold(input logic [15:0] s, input logic [15:0] w);
    logic [16:0] t;
    logic [15:0] e;
    t = {1'b0, s} + {1'b0, w};
    e = t[15:0] + {15'd0, t[16]};
    return {e[14:0], e[15]};
  endfunction

  function automatic logic [15:0] ref_raw(input logic [31:0] a, input int n, input logic [15:0] s);
    logic [15:0] r;
    r = s;
    for (int i = 0; i < n; i++) r = fold(r, mw(a + i));
    return r;
  endfunction

  function automatic logic [15:0] fin(input logic [15:0] s);
    return (s == 16'hFFFF) ? 16'h0 : s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [31:0] a, input logic [15:0] n, input logic [15:0] s);
    @(negedge clk);
    start = 1; start_addr = a; start_count = n; start_sum = s;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    int t;
    t = 0;
    while (!done && !suspended && t < 2000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic run_full(input string req, input logic [31:0] a, input logic [15:0] n, input logic [15:0] s);
    kick(a, n, s);
    wait_end();
    chk({req, " done"}, done, 1);
    chk({req, " result"}, result, fin(ref_raw(a, n, s)));
    chk({req, " cur_count"}, cur_count, 0);
    chk({req, " cur_addr"}, cur_addr, a + n);
  endtask

  task automatic t_reset();
    chk("R8 reset done", done, 0);
    chk("R8 reset suspended", suspended, 0);
    chk("R9 reset busy", busy, 0);
    chk("R4 reset rd_req", rd_req, 0);
  endtask

  task automatic t_zero();
    kick(32'h100, 0, 16'h1234);
    chk("R3 zero-count done next cycle", done, 1);
    chk("R3 zero-count result", result, 16'h1234);
    @(negedge clk);
    chk("R8 done pulse one cycle", done, 0);
    kick(32'h100, 0, 16'hFFFF);
    chk("R3 zero-count ones maps to zero", result, 16'h0000);
  endtask

  task automatic t_fold();
    run_full("R1 aligned four words", 32'h0000_0040, 4, 16'h0000);
    run_full("R1 long run", 32'h0000_1230, 37, 16'hBEEF);
    run_full("R4 start in lane 3", 32'h0000_0203, 5, 16'h0F0F);
    run_full("R4 start in lane 1", 32'h0000_0301, 2, 16'h8001);
  endtask

  task automatic t_ones();
    kick(32'h0000_00C3, 1, 16'hFFFF);
    wait_end();
    chk("R2 all-ones final maps to zero", result, 16'h0000);
  endtask

  task automatic t_mid();
    run_full("R7 stop mid-quadword", 32'h0000_0500, 2, 16'h5555);
    chk("R7 no rd_req after done", rd_req, 0);
  endtask

  task automatic t_wrap();
    run_full("R5 carry across 64K", 32'h0001_FFFE, 6, 16'h2468);
    chk("R5 upper address incremented", cur_addr[31:16], 16'h0002);
  endtask

  task automatic t_susp();
    logic [31:0] a2;
    logic [15:0] n2, s2;
    irq_pend = 1;
    kick(32'h0000_0701, 10, 16'h1357);
    wait_end();
    chk("R6 suspended pulse", suspended, 1);
    chk("R8 not done with suspended", done, 0);
    chk("R6 suspend addr", cur_addr, 32'h0000_0704);
    chk("R6 suspend count", cur_count, 7);
    chk("R6 suspend partial", result, ref_raw(32'h701, 3, 16'h1357));
    a2 = cur_addr; n2 = cur_count; s2 = result;
    @(negedge clk);
    chk("R8 suspended one cycle", suspended, 0);
    irq_pend = 0;
    kick(a2, n2, s2);
    wait_end();
    chk("R6 resume done", done, 1);
    chk("R6 resume equals full run", result, fin(ref_raw(32'h701, 10, 16'h1357)));
  endtask

  task automatic t_busy();
    kick(32'h0000_0900, 9, 16'h0101);
    kick(32'h0000_0100, 1, 16'hAAAA);
    wait_end();
    chk("R9 start while busy ignored", result, fin(ref_raw(32'h900, 9, 16'h0101)));
    chk("R9 address unaffected", cur_addr, 32'h0000_0909);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_fold();
    t_ones();
    t_mid();
    t_wrap();
    t_susp();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule